// File: doc/BRIEF.md
# Partitioned Operand Memory

This block is the word-addressed operand store that sits beside a wide modular multiplier. It holds four working operands and one modulus. Each is kept as a run of 32-bit words, with word 0 carrying the least significant bits. A host writes and reads single words through one address port. The top address bits pick the operand and the low bits pick the word. Reads come back through a two-stage pipeline.

The arithmetic datapath sees the store in two ways. First, it gets a wide parallel view of any one operand. Second, it has its own word write port, which it uses to place results into the working operands. A two-bit partition select sets which words are live for the datapath: the whole operand, only the low section, or only the high section. Words outside the live section reach the datapath as zero. Host readback always uses physical word indices, so in the high partition a host read of an operand starts at word 16.

When the host and the datapath try to write the same operand in the same cycle, the block raises a collision flag. The datapath write goes ahead and the host write is dropped.

Top module: `part_opmem`

## Requirements
- R1: After reset every stored word reads as zero, host_rdata is zero and collision is low.
- R2: host_addr[8:6] selects the operand (0 to 3 are working operands, 4 is the modulus) and host_addr[5:0] selects the word. A write happens in the cycle host_we is high, so consecutive words can be written on consecutive clocks.
- R3: Read data for an address appears on host_rdata after the second rising edge that samples that address, and not after the first.
- R4: Operand codes 5, 6 and 7 hold no storage. Host writes to them change nothing, and host reads of them return zero.
- R5: Word indices 48 to 63 hold no storage. Host or datapath writes to them change nothing, and host reads of them return zero.
- R6: With part_sel = 2'b11, dp_view carries all 48 words of the operand chosen by dp_view_sel, with word k at bits 32k+31:32k. A dp_view_sel above 4 gives an all-zero view.
- R7: With part_sel = 2'b01, words 0 to 15 of dp_view carry operand data and words 16 to 47 are zero.
- R8: With part_sel = 2'b10, words 16 to 47 of dp_view carry operand data and words 0 to 15 are zero.
- R9: With part_sel = 2'b00, dp_view is all zero.
- R10: collision is high exactly when host_we and dp_we are both high and host_addr[8:6] equals dp_dest. Because dp_dest can only name working operands, a host write to the modulus never collides.
- R11: During a collision the datapath word is written and the host write is dropped, even when both target the same word.
- R12: A host write and a datapath write to different operands in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 9 | Operand code in bits 8:6, word index in bits 5:0 |
| host_we | input | 1 | Host word write strobe |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word, two cycles after the address |
| collision | output | 1 | Host and datapath writing the same operand this cycle |
| part_sel | input | 2 | Partition select: 11 full, 01 low, 10 high, 00 none |
| dp_we | input | 1 | Datapath word write strobe |
| dp_dest | input | 2 | Datapath destination working operand |
| dp_word | input | 6 | Datapath destination word index |
| dp_wdata | input | 32 | Datapath write word |
| dp_view_sel | input | 3 | Operand code shown on dp_view |
| dp_view | output | 1536 | Partition-masked parallel operand view |

## Verification
If the operand and word decode is wrong, the wrong slot shows up on the second read of a full write-then-read sweep over every operand and word, within one pass. A wrong partition mask shows up at once on dp_view as nonzero words outside the live range, or as zeroed words inside it; these appear the same cycle part_sel changes. A wrong collision rule or write priority leaves an unexpected word in place. That is visible two cycles after the host reads that word back, and collision itself is wrong in the very cycle of the conflicting strobes.

// File: rtl/opmem_pkg.sv
`timescale 1ns/1ps
package opmem_pkg;

  typedef enum logic [1:0] {
    PART_NONE = 2'b00,
    PART_LOW  = 2'b01,
    PART_HIGH = 2'b10,
    PART_FULL = 2'b11
  } part_e;

  // Is word idx visible to the datapath under partition psel?
  function automatic logic word_live(input logic [1:0] psel, input int unsigned idx,
                                     input int unsigned low_words);
    case (part_e'(psel))
      PART_FULL: return 1'b1;
      PART_LOW:  return (idx < low_words);
      PART_HIGH: return (idx >= low_words);
      default:   return 1'b0;
    endcase
  endfunction

  // Does a host address land on real storage?
  function automatic logic slot_exists(input int unsigned op, input int unsigned idx,
                                       input int unsigned num_ops, input int unsigned op_words);
    return (op < num_ops) && (idx < op_words);
  endfunction

endpackage

// File: rtl/opmem_access.sv
`timescale 1ns/1ps
module opmem_access #(
  parameter int OP_W     = 3,
  parameter int IDX_W    = 6,
  parameter int DEST_W   = 2,
  parameter int NUM_OPS  = 5,
  parameter int OP_WORDS = 48
) (
  input  logic [OP_W+IDX_W-1:0] host_addr,
  input  logic                  host_we,
  input  logic                  dp_we,
  input  logic [DEST_W-1:0]     dp_dest,
  input  logic [IDX_W-1:0]      dp_word,
  output logic [OP_W-1:0]       host_op,
  output logic [IDX_W-1:0]      host_idx,
  output logic                  host_ok,
  output logic                  host_commit,
  output logic                  dp_commit,
  output logic                  collision
);
  import opmem_pkg::*;

  assign host_op  = host_addr[OP_W+IDX_W-1 -: OP_W];
  assign host_idx = host_addr[IDX_W-1:0];
  assign host_ok  = slot_exists(int'(host_op), int'(host_idx), NUM_OPS, OP_WORDS);

  // Conflict is judged per operand, regardless of word.
  assign collision   = host_we && dp_we && (host_op == OP_W'(dp_dest));
  assign host_commit = host_we && host_ok && !collision;
  assign dp_commit   = dp_we && (int'(dp_word) < OP_WORDS);

endmodule

// File: rtl/opmem_bank.sv
`timescale 1ns/1ps
module opmem_bank #(
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 6,
  parameter int OP_WORDS = 48,
  localparam int OPND_W  = WORD_W * OP_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [OPND_W-1:0] words
);
  logic [WORD_W-1:0] mem [OP_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < OP_WORDS; k++) mem[k] <= '0;
    end else if (wr_en && (int'(wr_idx) < OP_WORDS)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar k = 0; k < OP_WORDS; k++) begin : g_flat
    assign words[k*WORD_W +: WORD_W] = mem[k];
  end

endmodule

// File: rtl/opmem_view.sv
`timescale 1ns/1ps
module opmem_view #(
  parameter int WORD_W    = 32,
  parameter int OP_W      = 3,
  parameter int NUM_OPS   = 5,
  parameter int OP_WORDS  = 48,
  parameter int LOW_WORDS = 16,
  localparam int OPND_W   = WORD_W * OP_WORDS
) (
  input  logic [OPND_W-1:0] bank_words [NUM_OPS],
  input  logic [OP_W-1:0]   view_sel,
  input  logic [1:0]        part_sel,
  output logic [OPND_W-1:0] view
);
  import opmem_pkg::*;

  logic [OPND_W-1:0] chosen;

  always_comb begin
    chosen = '0;
    for (int b = 0; b < NUM_OPS; b++) begin
      if (view_sel == OP_W'(b)) chosen = bank_words[b];
    end
  end

  for (genvar k = 0; k < OP_WORDS; k++) begin : g_mask
    logic live;
    assign live = word_live(part_sel, k, LOW_WORDS);
    assign view[k*WORD_W +: WORD_W] = live ? chosen[k*WORD_W +: WORD_W] : '0;
  end

endmodule

// File: rtl/part_opmem.sv
`timescale 1ns/1ps
module part_opmem #(
  parameter int WORD_W    = 32,
  parameter int OP_WORDS  = 48,
  parameter int LOW_WORDS = 16,
  parameter int WORK_OPS  = 4,
  parameter int OP_W      = 3,
  parameter int IDX_W     = 6,
  localparam int NUM_OPS  = WORK_OPS + 1,
  localparam int DEST_W   = $clog2(WORK_OPS),
  localparam int ADDR_W   = OP_W + IDX_W,
  localparam int OPND_W   = WORD_W * OP_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              collision,
  input  logic [1:0]        part_sel,
  input  logic              dp_we,
  input  logic [DEST_W-1:0] dp_dest,
  input  logic [IDX_W-1:0]  dp_word,
  input  logic [WORD_W-1:0] dp_wdata,
  input  logic [OP_W-1:0]   dp_view_sel,
  output logic [OPND_W-1:0] dp_view
);

  // Named internal events (observed by the bound checker)
  logic [OP_W-1:0]  host_op;
  logic [IDX_W-1:0] host_idx;
  logic             host_ok;
  logic             host_commit;
  logic             dp_commit;

  opmem_access #(
    .OP_W(OP_W), .IDX_W(IDX_W), .DEST_W(DEST_W),
    .NUM_OPS(NUM_OPS), .OP_WORDS(OP_WORDS)
  ) u_access (
    .host_addr(host_addr), .host_we(host_we),
    .dp_we(dp_we), .dp_dest(dp_dest), .dp_word(dp_word),
    .host_op(host_op), .host_idx(host_idx), .host_ok(host_ok),
    .host_commit(host_commit), .dp_commit(dp_commit), .collision(collision)
  );

  logic [OPND_W-1:0] bank_words [NUM_OPS];

  for (genvar b = 0; b < NUM_OPS; b++) begin : g_bank
    logic              dp_hit, host_hit, wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;

    if (b < WORK_OPS) begin : g_work
      assign dp_hit = dp_commit && (dp_dest == DEST_W'(b));
    end else begin : g_mod
      assign dp_hit = 1'b0;
    end
    assign host_hit = host_commit && (host_op == OP_W'(b));
    // Datapath has priority on the shared bank write port.
    assign wr_en   = dp_hit || host_hit;
    assign wr_idx  = dp_hit ? dp_word  : host_idx;
    assign wr_data = dp_hit ? dp_wdata : host_wdata;

    opmem_bank #(.WORD_W(WORD_W), .IDX_W(IDX_W), .OP_WORDS(OP_WORDS)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .words(bank_words[b])
    );
  end

  opmem_view #(
    .WORD_W(WORD_W), .OP_W(OP_W), .NUM_OPS(NUM_OPS),
    .OP_WORDS(OP_WORDS), .LOW_WORDS(LOW_WORDS)
  ) u_view (
    .bank_words(bank_words), .view_sel(dp_view_sel),
    .part_sel(part_sel), .view(dp_view)
  );

  // Host read pipeline: address stage, then data stage.
  logic [OP_W-1:0]   rd_op_q;
  logic [IDX_W-1:0]  rd_idx_q;
  logic              rd_ok_q;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_op_q  <= '0;
      rd_idx_q <= '0;
      rd_ok_q  <= 1'b0;
    end else begin
      rd_op_q  <= host_op;
      rd_idx_q <= host_idx;
      rd_ok_q  <= host_ok;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_OPS; b++) begin
      if (rd_ok_q && (rd_op_q == OP_W'(b)))
        rd_word = bank_words[b][int'(rd_idx_q)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_word;
  end

endmodule

// File: rtl/opmem_chk.sv
`timescale 1ns/1ps
module opmem_chk #(
  parameter int WORD_W    = 32,
  parameter int OP_WORDS  = 48,
  parameter int LOW_WORDS = 16,
  parameter int WORK_OPS  = 4,
  parameter int OP_W      = 3,
  parameter int IDX_W     = 6,
  localparam int ADDR_W   = OP_W + IDX_W,
  localparam int OPND_W   = WORD_W * OP_WORDS,
  localparam int LOW_W    = WORD_W * LOW_WORDS
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_we,
  input logic              dp_we,
  input logic              collision,
  input logic              host_commit,
  input logic [1:0]        part_sel,
  input logic [WORD_W-1:0] host_rdata,
  input logic [OPND_W-1:0] dp_view
);
  logic bad_slot;
  assign bad_slot = (int'(host_addr[ADDR_W-1 -: OP_W]) > WORK_OPS) ||
                    (int'(host_addr[IDX_W-1:0]) >= OP_WORDS);

  AST_RESET_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> host_rdata == '0); // R1
  AST_BAD_SLOT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bad_slot, 2) |-> host_rdata == '0); // R4
  AST_VIEW_LOW_MASK: assert property (@(posedge clk) disable iff (rst)
    part_sel == 2'b01 |-> dp_view[OPND_W-1:LOW_W] == '0); // R7
  AST_VIEW_HIGH_MASK: assert property (@(posedge clk) disable iff (rst)
    part_sel == 2'b10 |-> dp_view[LOW_W-1:0] == '0); // R8
  AST_VIEW_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    part_sel == 2'b00 |-> dp_view == '0); // R9
  AST_COLLISION_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    collision |-> (host_we && dp_we)); // R10
  AST_COLLISION_DROPS_HOST: assert property (@(posedge clk) disable iff (rst)
    collision |-> !host_commit); // R11

endmodule

bind part_opmem opmem_chk #(
  .WORD_W(WORD_W), .OP_WORDS(OP_WORDS), .LOW_WORDS(LOW_WORDS),
  .WORK_OPS(WORK_OPS), .OP_W(OP_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
  .dp_we(dp_we), .collision(collision), .host_commit(host_commit),
  .part_sel(part_sel), .host_rdata(host_rdata), .dp_view(dp_view)
);

// File: tb/part_opmem_tb.sv
`timescale 1ns/1ps
module part_opmem_tb;
  localparam int NW = 48;
  localparam int LW = 16;
  localparam int NO = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [8:0]    host_addr;
  logic          host_we;
  logic [31:0]   host_wdata;
  logic [31:0]   host_rdata;
  logic          collision;
  logic [1:0]    part_sel;
  logic          dp_we;
  logic [1:0]    dp_dest;
  logic [5:0]    dp_word;
  logic [31:0]   dp_wdata;
  logic [2:0]    dp_view_sel;
  logic [1535:0] dp_view;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NO][NW];

  always #2.5 clk = ~clk;

  part_opmem u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .collision(collision),
    .part_sel(part_sel), .dp_we(dp_we), .dp_dest(dp_dest), .dp_word(dp_word),
    .dp_wdata(dp_wdata), .dp_view_sel(dp_view_sel), .dp_view(dp_view)
  );

  function automatic logic [31:0] pat(int op, int w, int salt);
    return ((op + 1) * 32'h0100_0193) ^ ((w + 1) * 32'h9E37_79B9) ^ (salt * 32'h0001_0003);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input int op, input int w, input logic [31:0] d);
    host_addr  = {3'(op), 6'(w)};
    host_wdata = d;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic host_read(input int op, input int w, output logic [31:0] d);
    host_addr = {3'(op), 6'(w)};
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic read_check(input int op, input int w, input string req);
    logic [31:0] got, exp;
    exp = (op < NO && w < NW) ? model[op][w] : 32'h0;
    host_read(op, w, got);
    check(got == exp, req, got, exp);
  endtask

  task automatic view_check(input logic [1:0] ps, input int op, input string req);
    int bad = 0;
    logic [31:0] first_act = 0, first_exp = 0;
    part_sel    = ps;
    dp_view_sel = 3'(op);
    #1;
    for (int w = 0; w < NW; w++) begin
      logic live;
      logic [31:0] exp;
      live = (ps[0] && w < LW) || (ps[1] && w >= LW);
      exp  = (live && op < NO) ? model[op][w] : 32'h0;
      if (dp_view[w*32 +: 32] !== exp) begin
        if (bad == 0) begin first_act = dp_view[w*32 +: 32]; first_exp = exp; end
        bad++;
      end
    end
    check(bad == 0, req, first_act, first_exp);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; host_addr = '0; host_we = 0; host_wdata = '0;
    part_sel = 2'b11; dp_we = 0; dp_dest = '0; dp_word = '0; dp_wdata = '0;
    dp_view_sel = '0;
    for (int o = 0; o < NO; o++) for (int w = 0; w < NW; w++) model[o][w] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(host_rdata == 0, "R1", host_rdata, 0);
    check(collision == 0, "R1", {31'b0, collision}, 0);
    read_check(0, 0, "R1");
    read_check(4, 47, "R1");
    view_check(2'b11, 2, "R1");

    // R2: back-to-back writes to every slot, one word per clock
    host_addr = {3'd0, 6'd0}; host_wdata = pat(0, 0, 0); host_we = 1'b1;
    for (int o = 0; o < NO; o++) begin
      for (int w = 0; w < NW; w++) begin
        host_addr  = {3'(o), 6'(w)};
        host_wdata = pat(o, w, 0);
        model[o][w] = pat(o, w, 0);
        @(negedge clk);
      end
    end
    host_we = 1'b0;
    for (int o = 0; o < NO; o++)
      for (int w = 0; w < NW; w++) read_check(o, w, "R2");

    // R3: latency is two edges, not one
    host_read(1, 5, d);
    host_addr = {3'd3, 6'd40};
    @(posedge clk); @(negedge clk);
    check(host_rdata == model[1][5], "R3", host_rdata, model[1][5]);
    @(posedge clk); @(negedge clk);
    check(host_rdata == model[3][40], "R3", host_rdata, model[3][40]);

    // R4: operand codes 5..7 hold nothing
    for (int o = 5; o < 8; o++)
      for (int w = 0; w < NW; w++) host_write(o, w, 32'hFFFF_FFFF);
    for (int o = 5; o < 8; o++) begin
      read_check(o, 0, "R4");
      read_check(o, 47, "R4");
    end
    for (int o = 0; o < NO; o++)
      for (int w = 0; w < NW; w++) read_check(o, w, "R4");

    // R5: word indices 48..63 hold nothing (host and datapath)
    for (int w = NW; w < 64; w++) host_write(0, w, 32'hDEAD_BEEF);
    dp_we = 1'b1; dp_dest = 2'd1; dp_word = 6'd50; dp_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    dp_we = 1'b0;
    read_check(0, 48, "R5");
    read_check(0, 63, "R5");
    view_check(2'b11, 0, "R5");
    view_check(2'b11, 1, "R5");

    // R10 / R11: same operand, different words
    host_addr = {3'd1, 6'd3}; host_wdata = 32'h1111_1111; host_we = 1'b1;
    dp_we = 1'b1; dp_dest = 2'd1; dp_word = 6'd5; dp_wdata = 32'h2222_2222;
    #1;
    check(collision == 1'b1, "R10", {31'b0, collision}, 1);
    @(negedge clk);
    host_we = 1'b0; dp_we = 1'b0;
    model[1][5] = 32'h2222_2222;
    read_check(1, 3, "R11");
    read_check(1, 5, "R11");

    // R11: same operand, same word: datapath wins
    host_addr = {3'd2, 6'd7}; host_wdata = 32'h3333_3333; host_we = 1'b1;
    dp_we = 1'b1; dp_dest = 2'd2; dp_word = 6'd7; dp_wdata = 32'h4444_4444;
    #1;
    check(collision == 1'b1, "R10", {31'b0, collision}, 1);
    @(negedge clk);
    host_we = 1'b0; dp_we = 1'b0;
    model[2][7] = 32'h4444_4444;
    read_check(2, 7, "R11");

    // R12: different operands, both land
    host_addr = {3'd0, 6'd0}; host_wdata = 32'h5555_5555; host_we = 1'b1;
    dp_we = 1'b1; dp_dest = 2'd3; dp_word = 6'd0; dp_wdata = 32'h6666_6666;
    #1;
    check(collision == 1'b0, "R12", {31'b0, collision}, 0);
    @(negedge clk);
    host_we = 1'b0; dp_we = 1'b0;
    model[0][0] = 32'h5555_5555; model[3][0] = 32'h6666_6666;
    read_check(0, 0, "R12");
    read_check(3, 0, "R12");

    // R10: modulus never collides
    host_addr = {3'd4, 6'd1}; host_wdata = 32'h7777_7777; host_we = 1'b1;
    dp_we = 1'b1; dp_dest = 2'd0; dp_word = 6'd1; dp_wdata = 32'h8888_8888;
    #1;
    check(collision == 1'b0, "R10", {31'b0, collision}, 0);
    @(negedge clk);
    host_we = 1'b0; dp_we = 1'b0;
    model[4][1] = 32'h7777_7777; model[0][1] = 32'h8888_8888;
    read_check(4, 1, "R10");
    read_check(0, 1, "R10");

    // R6..R9: partition views for every operand
    for (int o = 0; o < NO; o++) begin
      view_check(2'b11, o, "R6");
      view_check(2'b01, o, "R7");
      view_check(2'b10, o, "R8");
      view_check(2'b00, o, "R9");
    end
    for (int o = 5; o < 8; o++) view_check(2'b11, o, "R6");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule